// File: doc/BRIEF.md
# Conditional-Clear Event Register Bank

This block holds a bank of event registers that hardware sets bit by bit and software clears over a small synchronous register bus. Each event register has a companion snapshot register. Reading an event register over the bus copies its value into the snapshot on the same clock edge. A later software write changes only those bits whose present value still equals the snapshot. An event that arrives between the read and the write therefore cannot be erased by a clear that was meant for older events.

A bit that a write cannot change because it moved since the read is left untouched, and a sticky inhibit flag records that this happened. Software clears the flag explicitly. The bank also holds a configuration byte that refuses writes while an external scrub-in-progress input is high. Hardware set pulses have priority over software writes in the same cycle, so a bit that is set and cleared together ends at 1.

Top module: `cond_event_bank`

## Requirements
- R1: After synchronous reset, every event register, snapshot register, the inhibit flag, the configuration byte and the read data are 0.
- R2: A read (bus_re) of address i, where 0 <= i < NUM_REGS, returns event register i on bus_rdata one cycle later. On that same edge, the snapshot register i takes the pre-edge value of event register i.
- R3: A read of address NUM_REGS+i returns snapshot register i and changes no state. Writes to snapshot addresses are ignored.
- R4: A write to event register i loads bus_wdata into every bit whose current value equals the matching snapshot bit.
- R5: In such a write, every bit whose current value differs from its snapshot bit keeps its value.
- R6: A write to an event register with at least one differing bit sets the inhibit flag. The flag is bit 0 of address 2*NUM_REGS and drives the inhibit port.
- R7: The inhibit flag stays at 1 until a write to address 2*NUM_REGS with bus_wdata bit 0 equal to 1. Other writes, including writes there with bit 0 equal to 0, leave it set.
- R8: A hardware set bit (hw_set bit 8*i+j sets register i bit j) forces that bit to 1 at the next edge, even when a software write clears it in the same cycle.
- R9: A write to address 2*NUM_REGS+1 stores bus_wdata in the configuration byte only while scrub_active is 0. The byte reads back at that address and drives cfg.
- R10: Reads of addresses above 2*NUM_REGS+1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hw_set | input | 8*NUM_REGS | Hardware set pulses, register i at bits 8*i+7..8*i |
| scrub_active | input | 1 | Scrub in progress; locks the configuration byte |
| events | output | 8*NUM_REGS | Current event registers, same layout as hw_set |
| inhibit | output | 1 | Sticky write-inhibit flag |
| cfg | output | 8 | Configuration byte |

## Verification
Two cases can fall in the same cycle. A hardware set pulse can arrive in the same cycle as a software write to the same register. A set pulse can also arrive in the same cycle as the read that takes the snapshot. The bench drives hw_set on the same clock edge as the bus strobe. In the first case it expects the set bit to end at 1 after a clearing write. In the second it expects the read data and the snapshot to show the pre-set value, and a following clearing write to leave the new bit standing and raise the inhibit flag.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int DW = 8;
    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t evt;
        byte_t snap;
    } slice_st_t;

    typedef struct packed {
        logic  inh;
        byte_t cfg;
        byte_t rdata;
    } top_st_t;
endpackage

// File: rtl/cwb_slice.sv
module cwb_slice
    import cwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  logic  rd_sel,
    input  byte_t wdata,
    input  byte_t hw_set,
    output byte_t evt,
    output byte_t snap,
    output logic  blocked
);
    slice_st_t st_d, st_q;
    byte_t     match;

    always_comb begin
        match   = ~(st_q.evt ^ st_q.snap);
        st_d    = st_q;
        blocked = 1'b0;
        if (rd_sel) begin
            st_d.snap = st_q.evt;
        end
        if (wr_sel) begin
            st_d.evt = (st_q.evt & ~match) | (wdata & match);
            blocked  = |(~match);
        end
        st_d.evt = st_d.evt | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt  = st_q.evt;
    assign snap = st_q.snap;
endmodule

// File: rtl/cond_event_bank.sv
module cond_event_bank
    import cwb_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int AW       = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_we,
    input  logic                   bus_re,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NUM_REGS*DW-1:0] hw_set,
    input  logic                   scrub_active,
    output logic [NUM_REGS*DW-1:0] events,
    output logic                   inhibit,
    output logic [DW-1:0]          cfg
);
    localparam int SNAP_BASE = NUM_REGS;
    localparam int STAT_ADDR = 2 * NUM_REGS;
    localparam int CFG_ADDR  = 2 * NUM_REGS + 1;

    logic [NUM_REGS*DW-1:0] snaps;
    logic [NUM_REGS-1:0]    blk;
    top_st_t                st_d, st_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
        logic wr_sel, rd_sel;
        assign wr_sel = bus_we && (bus_addr == AW'(g));
        assign rd_sel = bus_re && (bus_addr == AW'(g));
        cwb_slice u_slice (
            .clk     (clk),
            .rst     (rst),
            .wr_sel  (wr_sel),
            .rd_sel  (rd_sel),
            .wdata   (bus_wdata),
            .hw_set  (hw_set[g*DW +: DW]),
            .evt     (events[g*DW +: DW]),
            .snap    (snaps[g*DW +: DW]),
            .blocked (blk[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_we && bus_addr == AW'(STAT_ADDR) && bus_wdata[0]) begin
            st_d.inh = 1'b0;
        end
        if (|blk) begin
            st_d.inh = 1'b1;
        end
        if (bus_we && bus_addr == AW'(CFG_ADDR) && !scrub_active) begin
            st_d.cfg = bus_wdata;
        end
        if (bus_re) begin
            st_d.rdata = '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                if (bus_addr == AW'(i)) begin
                    st_d.rdata = events[i*DW +: DW];
                end
                if (bus_addr == AW'(SNAP_BASE + i)) begin
                    st_d.rdata = snaps[i*DW +: DW];
                end
            end
            if (bus_addr == AW'(STAT_ADDR)) begin
                st_d.rdata = {{(DW-1){1'b0}}, st_q.inh};
            end
            if (bus_addr == AW'(CFG_ADDR)) begin
                st_d.rdata = st_q.cfg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign inhibit   = st_q.inh;
    assign cfg       = st_q.cfg;
endmodule

// File: rtl/cond_event_bank_chk.sv
module cond_event_bank_chk
    import cwb_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int AW       = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_we,
    input logic                   bus_re,
    input logic [DW-1:0]          bus_wdata,
    input logic [NUM_REGS*DW-1:0] hw_set,
    input logic                   scrub_active,
    input logic [NUM_REGS*DW-1:0] events,
    input logic [NUM_REGS*DW-1:0] snaps,
    input logic                   inhibit,
    input logic [DW-1:0]          cfg
);
    localparam int STAT_ADDR = 2 * NUM_REGS;
    localparam int CFG_ADDR  = 2 * NUM_REGS + 1;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((events & $past(hw_set)) == $past(hw_set))); // R8

    AST_INH_STICKY: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !(bus_we && bus_addr == AW'(STAT_ADDR) && bus_wdata[0])) |=> inhibit); // R7

    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(CFG_ADDR) && scrub_active) |=> $stable(cfg)); // R9

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        AST_SNAP_COPY: assert property (@(posedge clk) disable iff (rst)
            (bus_re && bus_addr == AW'(g)) |=>
            (snaps[g*DW +: DW] == $past(events[g*DW +: DW]))); // R2

        AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == AW'(g)) |=>
            ((events[g*DW +: DW] & $past((events[g*DW +: DW] ^ snaps[g*DW +: DW]) & ~hw_set[g*DW +: DW]))
             == ($past(events[g*DW +: DW]) & $past((events[g*DW +: DW] ^ snaps[g*DW +: DW]) & ~hw_set[g*DW +: DW])))); // R5

        AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == AW'(g) && (events[g*DW +: DW] != snaps[g*DW +: DW])) |=> inhibit); // R6
    end
endmodule

bind cond_event_bank cond_event_bank_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_wdata    (bus_wdata),
    .hw_set       (hw_set),
    .scrub_active (scrub_active),
    .events       (events),
    .snaps        (snaps),
    .inhibit      (inhibit),
    .cfg          (cfg)
);

// File: tb/cond_event_bank_test.sv
module cond_event_bank_test;
    localparam int N  = 5;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_we, bus_re;
    logic [7:0]    bus_wdata, bus_rdata;
    logic [N*8-1:0] hw_set, events;
    logic          scrub_active, inhibit;
    logic [7:0]    cfg;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cond_event_bank #(.NUM_REGS(N), .AW(AW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set(hw_set), .scrub_active(scrub_active), .events(events),
        .inhibit(inhibit), .cfg(cfg)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] ev(input int i);
        return events[i*8 +: 8];
    endfunction

    task automatic idle();
        bus_we = 0; bus_re = 0; bus_wdata = '0; bus_addr = '0; hw_set = '0;
    endtask

    task automatic bus_write(input int a, input logic [7:0] d, input logic [N*8-1:0] hs);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1; hw_set = hs;
        @(negedge clk);
        idle();
    endtask

    task automatic bus_read(input int a, input logic [N*8-1:0] hs, output logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_re = 1; hw_set = hs;
        @(negedge clk);
        d = bus_rdata;
        idle();
    endtask

    task automatic pulse_set(input logic [N*8-1:0] hs);
        @(negedge clk);
        hw_set = hs;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 events", events, '0);
        check("R1 inhibit", inhibit, 0);
        check("R1 cfg", cfg, 0);
        check("R1 rdata", bus_rdata, 0);
        bus_read(N + 2, '0, d);
        check("R1 snapshot", d, 0);
    endtask

    task automatic t_basic_clear();
        logic [7:0] d;
        pulse_set(40'h0F);
        bus_read(0, '0, d);
        check("R2 read event", d, 8'h0F);
        bus_read(N + 0, '0, d);
        check("R3 snapshot read", d, 8'h0F);
        bus_write(0, 8'h00, '0);
        check("R4 matched clear", ev(0), 8'h00);
        check("R4 no inhibit", inhibit, 0);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        pulse_set(40'h03 << 8);
        bus_read(1, '0, d);
        check("R2 read reg1", d, 8'h03);
        pulse_set(40'h10 << 8);
        bus_write(1, 8'h00, '0);
        check("R5 new bit kept", ev(1), 8'h10);
        check("R6 inhibit set", inhibit, 1);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        bus_write(2, 8'h00, '0);
        check("R7 kept after other write", inhibit, 1);
        bus_write(2 * N, 8'h00, '0);
        check("R7 kept after bit0=0", inhibit, 1);
        bus_read(2 * N, '0, d);
        check("R6 status read", d, 8'h01);
        bus_write(2 * N, 8'h01, '0);
        check("R7 cleared", inhibit, 0);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        bus_write(3, 8'h00, 40'h80 << 24);
        check("R8 set beats clear", ev(3), 8'h80);
        check("R8 matched no inhibit", inhibit, 0);
        bus_read(4, 40'h01 << 32, d);
        check("R2 read pre-set value", d, 8'h00);
        bus_read(N + 4, '0, d);
        check("R2 snapshot pre-set", d, 8'h00);
        check("R8 set during read", ev(4), 8'h01);
        bus_write(4, 8'h00, '0);
        check("R5 unread bit kept", ev(4), 8'h01);
        check("R6 inhibit from collide", inhibit, 1);
        bus_write(2 * N, 8'h01, '0);
    endtask

    task automatic t_cfg();
        logic [7:0] d;
        bus_write(2 * N + 1, 8'h5A, '0);
        check("R9 cfg stored", cfg, 8'h5A);
        scrub_active = 1;
        bus_write(2 * N + 1, 8'hA5, '0);
        check("R9 cfg locked", cfg, 8'h5A);
        scrub_active = 0;
        bus_read(2 * N + 1, '0, d);
        check("R9 cfg readback", d, 8'h5A);
    endtask

    task automatic t_misc();
        logic [7:0] d;
        bus_write(N + 1, 8'hFF, '0);
        bus_read(N + 1, '0, d);
        check("R3 snapshot write ignored", d, 8'h03);
        check("R3 event unaffected", ev(1), 8'h10);
        bus_read(13, '0, d);
        check("R10 unused reads 0", d, 8'h00);
    endtask

    initial begin
        #50000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        scrub_active = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic_clear();
        t_protect();
        t_sticky();
        t_collide();
        t_cfg();
        t_misc();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule